// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block sits at the end of the decode stage of a five-stage scalar pipeline (fetch, decode, execute, access, writeback). It picks the value of each of the two source operands of the decoding instruction. The candidates are the register-file read port, the result the ALU is producing in execute this cycle, and the result the access stage is presenting this cycle. The access-stage value is either cache load data or an ALU result that was passed through. The chosen values are captured in flops, and those flops feed the ALU in the next cycle.

Register tags of producers in execute and access are compared against the decode sources, and the newest producer wins. A register-file read that collides with the writeback write in the same cycle returns the data being written. Load data only exists at the end of access. A load in execute whose destination a decode source names therefore cannot be forwarded. In that case the block raises a stall that freezes fetch and decode for one cycle, and it hands a bubble to execute.

Top module: `operand_bypass_unit`

## Requirements
- R1: While `rst_n` is low, `opnd_a_q`, `opnd_b_q` and `issue_valid_q` are zero, whatever the inputs.
- R2: With no matching producer, an operand selects the register file (select code 0), and the flop takes the register-file data at the next clock edge.
- R3: When a valid non-load instruction in execute writes a nonzero register equal to a source, that source selects code 1, and its flop takes `exe_result` at the next edge.
- R4: When only a valid access-stage instruction writes a nonzero register equal to a source, that source selects code 2, and its flop takes `acc_result` at the next edge.
- R5: When execute and access both qualify for the same source, execute wins (code 1).
- R6: Register 0 never matches a producer, and a producer whose valid bit is low never matches. Such a source reads the register file.
- R7: On the register-file path, a valid writeback to the same nonzero register replaces the read data with `wb_data`. Execute and access producers take precedence over writeback.
- R8: A valid decode instruction with either source equal to the nonzero destination of a valid load in execute raises `stall` in that cycle. At the next edge, `issue_valid_q` becomes 0 and both operand flops keep their values.
- R9: Without a stall, `issue_valid_q` takes `dec_valid` at each edge.
- R10: `stall` stays low when `dec_valid` is low, when the execute instruction is not a load, or when its destination is 0 or matches neither source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_src_a | input | 5 | First source register tag |
| dec_src_b | input | 5 | Second source register tag |
| rf_data_a | input | 32 | Register-file read data for source A |
| rf_data_b | input | 32 | Register-file read data for source B |
| exe_valid | input | 1 | Execute stage instruction writes a register |
| exe_is_load | input | 1 | Execute stage instruction is a load |
| exe_dst | input | 5 | Execute stage destination tag |
| exe_result | input | 32 | Live ALU output |
| acc_valid | input | 1 | Access stage instruction writes a register |
| acc_dst | input | 5 | Access stage destination tag |
| acc_result | input | 32 | Live access-stage output |
| wb_valid | input | 1 | Writeback is writing the register file |
| wb_dst | input | 5 | Writeback destination tag |
| wb_data | input | 32 | Writeback data |
| sel_a | output | 2 | Source A select: 0 register file, 1 execute, 2 access |
| sel_b | output | 2 | Source B select, same coding |
| stall | output | 1 | Freeze fetch and decode this cycle |
| opnd_a_q | output | 32 | Registered ALU operand A |
| opnd_b_q | output | 32 | Registered ALU operand B |
| issue_valid_q | output | 1 | Instruction in execute next cycle is real (0 on bubble) |

## Verification
A wrong tag comparison or priority shows up immediately on `sel_a`/`sel_b`, in the same cycle the dependent instruction sits in decode. One clock edge later, the operand flops then carry the wrong producer's data. A broken interlock appears at once as a wrong `stall` level. One edge later it shows as an operand flop that moved when it should have held, or as a bubble that was missing or spurious on `issue_valid_q`. The sweep covers every combination of small source and destination tags and every valid and load bit. So each case is exposed within one cycle of the pattern that triggers it.

// File: rtl/opbyp_pkg.sv
package opbyp_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_EXE = 2'd1,
    SEL_ACC = 2'd2
  } opnd_sel_t;
endpackage

// File: rtl/opbyp_src_select.sv
module opbyp_src_select
  import opbyp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5
) (
  input  logic [TAG_W-1:0]  src,
  input  logic [DATA_W-1:0] rf_data,
  input  logic              exe_valid,
  input  logic              exe_is_load,
  input  logic [TAG_W-1:0]  exe_dst,
  input  logic [DATA_W-1:0] exe_result,
  input  logic              acc_valid,
  input  logic [TAG_W-1:0]  acc_dst,
  input  logic [DATA_W-1:0] acc_result,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_dst,
  input  logic [DATA_W-1:0] wb_data,
  output opnd_sel_t         sel,
  output logic [DATA_W-1:0] value,
  output logic              load_hit
);
  logic src_live;
  logic exe_tag_eq;
  logic exe_hit;
  logic acc_hit;
  logic wb_hit;
  logic [DATA_W-1:0] rf_path;

  // Register 0 is hard-wired, so it never takes a forwarded value.
  assign src_live   = (src != '0);
  assign exe_tag_eq = exe_valid && src_live && (exe_dst == src);
  assign exe_hit    = exe_tag_eq && !exe_is_load;
  assign load_hit   = exe_tag_eq && exe_is_load;
  assign acc_hit    = acc_valid && src_live && (acc_dst == src);
  assign wb_hit     = wb_valid && src_live && (wb_dst == src);

  // Write-before-read on the register-file port.
  assign rf_path = wb_hit ? wb_data : rf_data;

  always_comb begin
    if (exe_hit) begin
      sel   = SEL_EXE;
      value = exe_result;
    end else if (acc_hit) begin
      sel   = SEL_ACC;
      value = acc_result;
    end else begin
      sel   = SEL_RF;
      value = rf_path;
    end
  end

  // R6: a zero source must always come from the register file
  always_comb begin
    assert_zero_src_rf_R6: assert (src_live || (sel == SEL_RF && value == rf_data));
  end
endmodule

// File: rtl/opbyp_interlock.sv
module opbyp_interlock #(
  parameter int NUM_SRC = 2
) (
  input  logic               dec_valid,
  input  logic [NUM_SRC-1:0] load_hit,
  output logic               stall
);
  // Load data is not ready until the end of access: hold decode one cycle.
  assign stall = dec_valid && (|load_hit);
endmodule

// File: rtl/opbyp_operand_reg.sv
module opbyp_operand_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/operand_bypass_unit.sv
module operand_bypass_unit
  import opbyp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 32,
  localparam int TAG_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [TAG_W-1:0]  dec_src_a,
  input  logic [TAG_W-1:0]  dec_src_b,
  input  logic [DATA_W-1:0] rf_data_a,
  input  logic [DATA_W-1:0] rf_data_b,
  input  logic              exe_valid,
  input  logic              exe_is_load,
  input  logic [TAG_W-1:0]  exe_dst,
  input  logic [DATA_W-1:0] exe_result,
  input  logic              acc_valid,
  input  logic [TAG_W-1:0]  acc_dst,
  input  logic [DATA_W-1:0] acc_result,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_dst,
  input  logic [DATA_W-1:0] wb_data,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic              stall,
  output logic [DATA_W-1:0] opnd_a_q,
  output logic [DATA_W-1:0] opnd_b_q,
  output logic              issue_valid_q
);
  localparam int NUM_SRC = 2;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [TAG_W-1:0]  src_vec   [NUM_SRC];
  logic [DATA_W-1:0] rf_vec    [NUM_SRC];
  logic [DATA_W-1:0] value_vec [NUM_SRC];
  logic [DATA_W-1:0] q_vec     [NUM_SRC];
  opnd_sel_t         sel_vec   [NUM_SRC];
  logic [NUM_SRC-1:0] load_hit;
  logic operand_en;
  logic issue_valid_nxt;

  assign src_vec[0] = dec_src_a;
  assign src_vec[1] = dec_src_b;
  assign rf_vec[0]  = rf_data_a;
  assign rf_vec[1]  = rf_data_b;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      opbyp_src_select #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_sel (
        .src        (src_vec[i]),
        .rf_data    (rf_vec[i]),
        .exe_valid  (exe_valid),
        .exe_is_load(exe_is_load),
        .exe_dst    (exe_dst),
        .exe_result (exe_result),
        .acc_valid  (acc_valid),
        .acc_dst    (acc_dst),
        .acc_result (acc_result),
        .wb_valid   (wb_valid),
        .wb_dst     (wb_dst),
        .wb_data    (wb_data),
        .sel        (sel_vec[i]),
        .value      (value_vec[i]),
        .load_hit   (load_hit[i])
      );

      opbyp_operand_reg #(.DATA_W(DATA_W)) u_reg (
        .clk       (clk),
        .rst_sync_n(rst_sync_n),
        .load_en   (operand_en),
        .d         (value_vec[i]),
        .q         (q_vec[i])
      );
    end
  endgenerate

  opbyp_interlock #(.NUM_SRC(NUM_SRC)) u_lock (
    .dec_valid(dec_valid),
    .load_hit (load_hit),
    .stall    (stall)
  );

  assign operand_en = !stall;
  assign sel_a      = sel_vec[0];
  assign sel_b      = sel_vec[1];
  assign opnd_a_q   = q_vec[0];
  assign opnd_b_q   = q_vec[1];

  // Issue-valid flop: a stall turns the execute slot into a bubble.
  always_comb begin
    issue_valid_nxt = dec_valid && !stall;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      issue_valid_q <= 1'b0;
    end else begin
      issue_valid_q <= issue_valid_nxt;
    end
  end

  // Assertions
  assert_sel_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_a != 2'd3) && (sel_b != 2'd3));

  assert_exe_forward_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_a == SEL_EXE && !stall) |=> (opnd_a_q == $past(exe_result)));

  assert_acc_forward_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_b == SEL_ACC && !stall) |=> (opnd_b_q == $past(acc_result)));

  assert_stall_bubble_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall |=> (!issue_valid_q && $stable(opnd_a_q) && $stable(opnd_b_q)));

  assert_stall_cause_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall |-> (dec_valid && exe_valid && exe_is_load && exe_dst != '0));

  assert_issue_follow_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !stall |=> (issue_valid_q == $past(dec_valid)));
endmodule

// File: tb/test_operand_bypass_unit.sv
module test_operand_bypass_unit;
  localparam int DW = 32;
  localparam int TW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dec_valid;
  logic [TW-1:0] dec_src_a, dec_src_b;
  logic [DW-1:0] rf_data_a, rf_data_b;
  logic          exe_valid, exe_is_load;
  logic [TW-1:0] exe_dst;
  logic [DW-1:0] exe_result;
  logic          acc_valid;
  logic [TW-1:0] acc_dst;
  logic [DW-1:0] acc_result;
  logic          wb_valid;
  logic [TW-1:0] wb_dst;
  logic [DW-1:0] wb_data;
  logic [1:0]    sel_a, sel_b;
  logic          stall;
  logic [DW-1:0] opnd_a_q, opnd_b_q;
  logic          issue_valid_q;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  always #4 clk = ~clk;  // 8 ns period

  operand_bypass_unit i_operand_bypass_unit (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
    .exe_valid(exe_valid), .exe_is_load(exe_is_load), .exe_dst(exe_dst),
    .exe_result(exe_result), .acc_valid(acc_valid), .acc_dst(acc_dst),
    .acc_result(acc_result), .wb_valid(wb_valid), .wb_dst(wb_dst),
    .wb_data(wb_data), .sel_a(sel_a), .sel_b(sel_b), .stall(stall),
    .opnd_a_q(opnd_a_q), .opnd_b_q(opnd_b_q), .issue_valid_q(issue_valid_q)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Reference model for one source.
  function automatic void model_src(
      input logic [TW-1:0] src, input logic [DW-1:0] rf,
      output logic [1:0] sel, output logic [DW-1:0] val, output string tag);
    logic live, eh, ah, wh, lost;
    live = (src != 0);
    eh = exe_valid && !exe_is_load && live && exe_dst == src;
    ah = acc_valid && live && acc_dst == src;
    wh = wb_valid && live && wb_dst == src;
    lost = (!live && ((exe_dst == 0) || (acc_dst == 0) || (wb_dst == 0))) ||
           (!exe_valid && exe_dst == src) || (!acc_valid && acc_dst == src);
    if (eh)      begin sel = 2'd1; val = exe_result; end
    else if (ah) begin sel = 2'd2; val = acc_result; end
    else if (wh) begin sel = 2'd0; val = wb_data;    end
    else         begin sel = 2'd0; val = rf;         end
    if (eh && ah)  tag = "R5";
    else if (eh)   tag = "R3";
    else if (ah)   tag = "R4";
    else if (wh)   tag = "R7";
    else if (lost) tag = "R6";
    else           tag = "R2";
  endfunction

  always @(posedge clk) cyc++;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [DW-1:0] exp_a, exp_b, val_a, val_b;
    logic [1:0]    es_a, es_b;
    logic          exp_stall, exp_iv;
    string         tag_a, tag_b;

    // R1: outputs held at zero during reset with busy inputs
    rst_n = 1'b0;
    dec_valid = 1; dec_src_a = 5'd1; dec_src_b = 5'd2;
    rf_data_a = 32'hAAAA_0001; rf_data_b = 32'hBBBB_0002;
    exe_valid = 1; exe_is_load = 0; exe_dst = 5'd1; exe_result = 32'h1234_5678;
    acc_valid = 1; acc_dst = 5'd2; acc_result = 32'h0BAD_F00D;
    wb_valid = 1; wb_dst = 5'd3; wb_data = 32'hCAFE_0003;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", opnd_a_q, '0);
    check("R1", opnd_b_q, '0);
    check("R1", {31'b0, issue_valid_q}, '0);

    // Quiet inputs, release reset, wait for the internal synchronizer.
    dec_valid = 0; exe_valid = 0; acc_valid = 0; wb_valid = 0;
    rf_data_a = '0; rf_data_b = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_a = '0;
    exp_b = '0;

    // Sweep: tags 0..3 on every field, every valid/load bit.
    for (int code = 0; code < 32768; code++) begin
      @(negedge clk);
      dec_src_a   = TW'(code & 3);
      dec_src_b   = TW'((code >> 2) & 3);
      exe_dst     = TW'((code >> 4) & 3);
      acc_dst     = TW'((code >> 6) & 3);
      wb_dst      = TW'((code >> 8) & 3);
      exe_valid   = code[10];
      acc_valid   = code[11];
      exe_is_load = code[12];
      wb_valid    = code[13];
      dec_valid   = code[14];
      rf_data_a   = $urandom;
      rf_data_b   = $urandom;
      exe_result  = $urandom;
      acc_result  = $urandom;
      wb_data     = $urandom;
      #1;
      model_src(dec_src_a, rf_data_a, es_a, val_a, tag_a);
      model_src(dec_src_b, rf_data_b, es_b, val_b, tag_b);
      exp_stall = dec_valid && exe_valid && exe_is_load && exe_dst != 0 &&
                  (exe_dst == dec_src_a || exe_dst == dec_src_b);
      exp_iv = dec_valid && !exp_stall;
      check(tag_a, {30'b0, sel_a}, {30'b0, es_a});
      check(tag_b, {30'b0, sel_b}, {30'b0, es_b});
      check(exp_stall ? "R8" : "R10", {31'b0, stall}, {31'b0, exp_stall});
      if (!exp_stall) begin
        exp_a = val_a;
        exp_b = val_b;
      end else begin
        tag_a = "R8";
        tag_b = "R8";
      end
      @(posedge clk);
      #1;
      check(tag_a, opnd_a_q, exp_a);
      check(tag_b, opnd_b_q, exp_b);
      check(exp_stall ? "R8" : "R9", {31'b0, issue_valid_q}, {31'b0, exp_iv});
    end

    // Dependent pair: SUB writes r10, next AND reads r10 (execute forward, R3),
    // then one cycle later the same read comes from access (R4).
    @(negedge clk);
    dec_valid = 1; dec_src_a = 5'd10; dec_src_b = 5'd0;
    exe_valid = 1; exe_is_load = 0; exe_dst = 5'd10; exe_result = 32'd7 - 32'd3;
    acc_valid = 0; wb_valid = 0; rf_data_a = 32'hDEAD; rf_data_b = 32'h3;
    @(posedge clk); #1;
    check("R3", opnd_a_q, 32'd4);
    check("R6", opnd_b_q, 32'h3);
    @(negedge clk);
    exe_valid = 0; acc_valid = 1; acc_dst = 5'd10; acc_result = 32'd4;
    @(posedge clk); #1;
    check("R4", opnd_a_q, 32'd4);

    // Load-use: load r5 in execute, consumer reads r5 -> one stall, then access.
    @(negedge clk);
    dec_src_a = 5'd5; dec_src_b = 5'd5;
    exe_valid = 1; exe_is_load = 1; exe_dst = 5'd5; acc_valid = 0;
    #1;
    check("R8", {31'b0, stall}, 32'd1);
    @(posedge clk); #1;
    check("R8", opnd_a_q, 32'd4);
    check("R8", {31'b0, issue_valid_q}, 32'd0);
    @(negedge clk);
    exe_valid = 0; acc_valid = 1; acc_dst = 5'd5; acc_result = 32'h5EED;
    #1;
    check("R10", {31'b0, stall}, 32'd0);
    @(posedge clk); #1;
    check("R4", opnd_b_q, 32'h5EED);
    check("R9", {31'b0, issue_valid_q}, 32'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule